// File: doc/BRIEF.md
# PCIe Far-End Receiver Detect Sequencer

This block runs the far-end receiver detection that a PCIe transmit lane performs during link training. Link-training logic on the PIPE-side clock raises a detect request while the lane sits in power state P1. The block then keeps the transmitter in electrical idle and hands the request to a measurement engine. That engine runs from a separate fixed 125 MHz monitor clock. It raises a step-enable command toward the analog transmit buffer and counts monitor cycles until an external line-threshold comparator reports that the line has risen.

A slow rise means the line carries the larger time constant of a terminated receiver, so a slow rise counts as a receiver present. A rise that comes early counts as no receiver. If the comparator never trips before a timeout, the result is also a receiver present. The result and a completion toggle pass back to the PIPE domain through synchronizers. There the block produces a one-cycle done pulse together with a 3-bit status code.

All of the pins are plain control and status signals. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure. A request that cannot be served is simply dropped. Each clock domain has its own synchronous, active-high reset.

Top module: `rx_detect_seq`

## Requirements
- R1: A detection starts, and `step_en` rises, only when `detect_req` is high, `power_state` equals P1 (encoding 2'b10; P0=2'b00, P0s=2'b01, P2=2'b11) and no detection is in progress.
- R2: `elec_idle_force` is high in every cycle where `power_state` is P1, and in every cycle from the acceptance of a detection until its done pulse, including every cycle in which `step_en` is high.
- R3: Once `elec_idle_force` rises, it stays high for at least MIN_IDLE_CYC pipe cycles. If P1 lasts one cycle and no detection runs, it is high for exactly MIN_IDLE_CYC cycles.
- R4: Suppose the comparator input `line_cmp` rises d monitor cycles after `step_en` rises (d=0 means it is high before the next monitor edge). The result is receiver present exactly when d + SYNC_STAGES >= THRESH_CYC, and no receiver otherwise.
- R5: If `line_cmp` is not seen high before the count reaches TIMEOUT_CYC-1, the measurement ends with the result receiver present.
- R6: Each accepted detection produces exactly one `done` pulse, and that pulse lasts one pipe clock cycle.
- R7: In the `done` cycle, `status` is 3'b011 for receiver present and 3'b000 for no receiver. In every other cycle `status` is 3'b000.
- R8: While `power_state` is not P1, `status` is 3'b000, and this includes a `done` cycle.
- R9: A request made while `power_state` is not P1 is ignored. No step is launched and no `done` pulse follows.
- R10: A request made while a detection is in progress is ignored. The running detection still yields a single `done` pulse and no second step follows.
- R11: `step_en` falls on the monitor edge where the measurement ends, which is before the `done` pulse appears.
- R12: After reset, with `power_state` at P0, `step_en`, `done`, `status` and `elec_idle_force` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pipe_clk | input | 1 | PIPE-side clock |
| pipe_rst | input | 1 | Synchronous active-high reset, PIPE domain |
| mon_clk | input | 1 | Fixed 125 MHz measurement clock |
| mon_rst | input | 1 | Synchronous active-high reset, monitor domain |
| power_state | input | 2 | Lane power state (P0=00, P0s=01, P1=10, P2=11) |
| detect_req | input | 1 | Request to run a receiver detection |
| line_cmp | input | 1 | Line threshold comparator, high once the line has risen |
| elec_idle_force | output | 1 | Holds the transmitter in electrical idle |
| step_en | output | 1 | Commands the transmit buffer to drive the voltage step |
| done | output | 1 | One-cycle completion pulse, PIPE domain |
| status | output | 3 | Detection result code, valid with `done` |

## Verification
The hardest case to reach from the ports is the exact decision boundary. The comparator edge has to land on a chosen monitor cycle relative to the step. Between the request and that edge lie a synchronizer in each direction and a second synchronizer on the comparator. The stimulus therefore waits for `step_en` on monitor falling edges and counts a chosen number of further monitor cycles before raising `line_cmp`, which places the edge at d = THRESH_CYC-3 and d = THRESH_CYC-2. A power-state change in the middle of a measurement, and requests made while a measurement is running, are driven in the same way: the bench waits for `step_en` and acts on it.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;
  typedef enum logic [1:0] {
    PWR_P0  = 2'b00,
    PWR_P0S = 2'b01,
    PWR_P1  = 2'b10,
    PWR_P2  = 2'b11
  } pwr_state_e;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_MEAS = 1'b1
  } meas_state_e;

  localparam logic [2:0] STAT_FOUND = 3'b011;
  localparam logic [2:0] STAT_NONE  = 3'b000;
endpackage

// File: rtl/rxdet_sync.sv
module rxdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxdet_pipe_ctl.sv
module rxdet_pipe_ctl
  import rxdet_pkg::*;
#(
  parameter int MIN_IDLE_CYC = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] power_state,
  input  logic       detect_req,
  input  logic       fin_tgl_async,
  input  logic       found_async,
  output logic       req_tgl,
  output logic       elec_idle_o,
  output logic       done_o,
  output logic [2:0] status_o
);
  localparam int HOLD_W = (MIN_IDLE_CYC < 2) ? 1 : $clog2(MIN_IDLE_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD =
    (MIN_IDLE_CYC > 0) ? HOLD_W'(MIN_IDLE_CYC - 1) : '0;

  logic              in_p1;
  logic              busy;
  logic              accept;
  logic              fin_sync;
  logic              fin_prev;
  logic              fin_edge;
  logic              want_idle;
  logic [HOLD_W-1:0] hold_cnt;
  logic [2:0]        status_r;

  assign in_p1  = (power_state == PWR_P1);
  assign accept = detect_req && in_p1 && !busy;

  rxdet_sync #(.STAGES(SYNC_STAGES)) u_fin_sync (
    .clk(clk), .rst(rst), .d(fin_tgl_async), .q(fin_sync)
  );

  assign fin_edge = fin_sync ^ fin_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      req_tgl  <= 1'b0;
      fin_prev <= 1'b0;
      done_o   <= 1'b0;
      status_r <= STAT_NONE;
    end else begin
      fin_prev <= fin_sync;
      done_o   <= fin_edge;
      status_r <= (fin_edge && found_async) ? STAT_FOUND : STAT_NONE;
      if (accept) begin
        busy    <= 1'b1;
        req_tgl <= ~req_tgl;
      end else if (fin_edge) begin
        busy <= 1'b0;
      end
    end
  end

  assign want_idle = in_p1 || busy;

  always_ff @(posedge clk) begin
    if (rst)                  hold_cnt <= '0;
    else if (want_idle)       hold_cnt <= HOLD_LOAD;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
  end

  assign elec_idle_o = want_idle || (hold_cnt != '0);
  assign status_o    = in_p1 ? status_r : STAT_NONE;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  status_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o != STAT_NONE) |-> done_o);
endmodule

// File: rtl/rxdet_mon_meas.sv
module rxdet_mon_meas
  import rxdet_pkg::*;
#(
  parameter int THRESH_CYC  = 20,
  parameter int TIMEOUT_CYC = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_tgl_async,
  input  logic line_cmp,
  output logic step_en,
  output logic fin_tgl,
  output logic found
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_THRESH = CNT_W'(THRESH_CYC);

  meas_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             req_sync;
  logic             req_prev;
  logic             start;
  logic             cmp_s;

  rxdet_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_tgl_async), .q(req_sync)
  );

  rxdet_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst(rst), .d(line_cmp), .q(cmp_s)
  );

  assign start = (req_sync ^ req_prev) && (state == MS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MS_IDLE;
      cnt      <= '0;
      req_prev <= 1'b0;
      step_en  <= 1'b0;
      fin_tgl  <= 1'b0;
      found    <= 1'b0;
    end else begin
      req_prev <= req_sync;
      case (state)
        MS_IDLE: begin
          if (start) begin
            state   <= MS_MEAS;
            cnt     <= '0;
            step_en <= 1'b1;
          end
        end
        MS_MEAS: begin
          if (cmp_s) begin
            found   <= (cnt >= CNT_THRESH);
            state   <= MS_IDLE;
            step_en <= 1'b0;
            fin_tgl <= ~fin_tgl;
          end else if (cnt == CNT_LAST) begin
            found   <= 1'b1;
            state   <= MS_IDLE;
            step_en <= 1'b0;
            fin_tgl <= ~fin_tgl;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  // R11
  step_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(step_en) |-> (fin_tgl != $past(fin_tgl)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == MS_MEAS) |-> (cnt <= CNT_LAST));
endmodule

// File: rtl/rx_detect_seq.sv
module rx_detect_seq
  import rxdet_pkg::*;
#(
  parameter int THRESH_CYC   = 20,
  parameter int TIMEOUT_CYC  = 60,
  parameter int MIN_IDLE_CYC = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       pipe_clk,
  input  logic       pipe_rst,
  input  logic       mon_clk,
  input  logic       mon_rst,
  input  logic [1:0] power_state,
  input  logic       detect_req,
  input  logic       line_cmp,
  output logic       elec_idle_force,
  output logic       step_en,
  output logic       done,
  output logic [2:0] status
);
  logic req_tgl;
  logic fin_tgl;
  logic found;

  rxdet_pipe_ctl #(
    .MIN_IDLE_CYC(MIN_IDLE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_pipe (
    .clk          (pipe_clk),
    .rst          (pipe_rst),
    .power_state  (power_state),
    .detect_req   (detect_req),
    .fin_tgl_async(fin_tgl),
    .found_async  (found),
    .req_tgl      (req_tgl),
    .elec_idle_o  (elec_idle_force),
    .done_o       (done),
    .status_o     (status)
  );

  rxdet_mon_meas #(
    .THRESH_CYC (THRESH_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_mon (
    .clk          (mon_clk),
    .rst          (mon_rst),
    .req_tgl_async(req_tgl),
    .line_cmp     (line_cmp),
    .step_en      (step_en),
    .fin_tgl      (fin_tgl),
    .found        (found)
  );

  // R2
  step_idle_chk: assert property (@(posedge mon_clk) disable iff (mon_rst || pipe_rst)
    step_en |-> elec_idle_force);
endmodule

// File: tb/rx_detect_seq_test.sv
`timescale 1ns/1ps
module rx_detect_seq_test;
  localparam int PIPE_PERIOD = 4;
  localparam int MON_PERIOD  = 8;
  localparam int THRESH      = 20;
  localparam int TMO         = 60;
  localparam int MINIDLE     = 3;
  localparam logic [1:0] P0 = 2'b00;
  localparam logic [1:0] P1 = 2'b10;

  logic pipe_clk = 0, mon_clk = 0, pipe_rst = 1, mon_rst = 1;
  logic [1:0] power_state = P0;
  logic detect_req = 0, line_cmp = 0;
  logic elec_idle_force, step_en, done;
  logic [2:0] status;

  int compared = 0, mismatched = 0;
  int done_cnt = 0, step_rises = 0;
  logic [2:0] last_status;
  logic se_prev = 0;

  rx_detect_seq #(.THRESH_CYC(THRESH), .TIMEOUT_CYC(TMO), .MIN_IDLE_CYC(MINIDLE)) uut (
    .pipe_clk(pipe_clk), .pipe_rst(pipe_rst), .mon_clk(mon_clk), .mon_rst(mon_rst),
    .power_state(power_state), .detect_req(detect_req), .line_cmp(line_cmp),
    .elec_idle_force(elec_idle_force), .step_en(step_en), .done(done), .status(status));

  always #(PIPE_PERIOD/2) pipe_clk = ~pipe_clk;
  always #(MON_PERIOD/2)  mon_clk  = ~mon_clk;

  always begin
    @(negedge pipe_clk); #1;
    if (!pipe_rst && done) begin
      done_cnt++;
      last_status = status;
    end
  end

  always begin
    @(negedge mon_clk); #1;
    if (!mon_rst && step_en && !se_prev) step_rises++;
    se_prev = step_en;
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_req();
    @(negedge pipe_clk); detect_req = 1;
    @(negedge pipe_clk); detect_req = 0;
  endtask

  // Run one detection; d<0 means the comparator never trips.
  task automatic run_detect(input string req, input int d, input logic [2:0] exp_stat,
                            input bit drop_p1);
    int n0;
    int w;
    n0 = done_cnt;
    pulse_req();
    w = 0;
    do begin @(negedge mon_clk); w++; end while (!step_en && w < 100);
    check({req, " step launched"}, step_en, 1);
    if (drop_p1) begin
      @(negedge pipe_clk); power_state = P0;
      #1 check("R2 idle held while busy outside P1", elec_idle_force, 1);
    end
    if (d >= 0) begin
      repeat (d) @(negedge mon_clk);
      line_cmp = 1;
    end
    w = 0;
    while (done_cnt == n0 && w < 500) begin @(negedge pipe_clk); w++; end
    check({req, " one done"}, done_cnt - n0, 1);
    check({req, " status"}, last_status, exp_stat);
    check("R11 step low at done", step_en, 0);
    @(negedge pipe_clk); #1;
    check("R7 status cleared after done", status, 0);
    line_cmp = 0;
    repeat (20) @(negedge pipe_clk);
    check("R6 no extra done", done_cnt - n0, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R12 step_en", step_en, 0);
    check("R12 done", done, 0);
    check("R12 status", status, 0);
    check("R12 elec_idle_force", elec_idle_force, 0);
  endtask

  task automatic t_min_idle();
    int hi;
    hi = 0;
    @(negedge pipe_clk); power_state = P1; #1 hi += elec_idle_force;
    check("R2 idle in P1", elec_idle_force, 1);
    @(negedge pipe_clk); power_state = P0; #1 hi += elec_idle_force;
    for (int i = 0; i < 6; i++) begin @(negedge pipe_clk); #1 hi += elec_idle_force; end
    check("R3 min idle hold", hi, MINIDLE);
  endtask

  task automatic t_not_p1();
    int d0, s0;
    d0 = done_cnt; s0 = step_rises;
    power_state = P0;
    pulse_req();
    repeat (100) @(negedge pipe_clk);
    check("R9 no step outside P1", step_rises - s0, 0);
    check("R9 no done outside P1", done_cnt - d0, 0);
  endtask

  task automatic t_busy();
    int d0, s0, w;
    d0 = done_cnt; s0 = step_rises;
    power_state = P1;
    pulse_req();
    w = 0;
    do begin @(negedge mon_clk); w++; end while (!step_en && w < 100);
    pulse_req();
    repeat (3) @(negedge mon_clk);
    pulse_req();
    repeat (5) @(negedge mon_clk);
    line_cmp = 1;
    repeat (150) @(negedge pipe_clk);
    line_cmp = 0;
    repeat (150) @(negedge pipe_clk);
    check("R10 single done", done_cnt - d0, 1);
    check("R10 single step", step_rises - s0, 1);
    check("R10 status of run", last_status, 0);
  endtask

  initial begin
    repeat (4) @(negedge mon_clk);
    pipe_rst = 0; mon_rst = 0;
    t_reset();
    t_min_idle();
    power_state = P1;
    run_detect("R4 fast rise none", 5, 3'b000, 0);
    run_detect("R4 slow rise present", 40, 3'b011, 0);
    run_detect("R4 boundary below", THRESH - 3, 3'b000, 0);
    run_detect("R4 boundary at", THRESH - 2, 3'b011, 0);
    run_detect("R5 timeout present", -1, 3'b011, 0);
    run_detect("R1 start in P1", 10, 3'b000, 0);
    run_detect("R8 status low outside P1", 40, 3'b000, 1);
    t_not_p1();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PIPE_PERIOD * 150000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule